// File: doc/BRIEF.md
# Shared Bus Ownership Claimer

This block wins ownership of a shared, multi-master bus on behalf of a DMA engine. The bus uses active-low request, grant and grant-acknowledge handshakes. The DMA engine raises a one-cycle demand. The block then asks for the bus and waits for the grant. If the grant-acknowledge line shows that another master still holds the bus, the block waits for that line to go high. It then waits for the cycle in flight to finish, which it sees when the data strobe and the transfer acknowledge are both high. After that it claims the bus by pulling grant-acknowledge low. It withdraws its request only after the claim.

The bus lines are asynchronous to the block clock, so each sensed line passes through a synchronizer chain before the state machine sees it. Each ownership period serves one burst. When the DMA engine signals that the burst is complete, the block drives grant-acknowledge high for one cycle, stops driving it, and goes back to idle. A new burst needs a fresh demand.

Top module: `busClaimer`

## Requirements
- R1: While reset is asserted and after it is released, busReqN=1, busAckOutN=1, busAckOe=0 and busOwned=0 until a demand arrives.
- R2: A demand (dmaReq=1) sampled while idle drives busReqN low after that clock edge.
- R3: Once requested, busReqN stays low and busOwned stays 0 until a low busGrantN has passed the synchronizer (SYNC_STAGES flops, default 2) and been seen by the state machine.
- R4: If the synchronized busAckIn is low when the grant is seen, the claim waits until the synchronized busAckIn is high.
- R5: The claim happens only after the synchronizer delay has passed with strobeN and xferAckN both sampled high, along with grant low and busAckIn high.
- R6: The claim drives busAckOe=1, busAckOutN=0 and busOwned=1. In that first claim cycle busReqN is still 0. From the next cycle busReqN is 1.
- R7: burstDone=1 sampled while owned gives exactly one cycle of busAckOutN=1 with busAckOe=1 and busOwned=0. In the following cycle busAckOe=0 and the block is idle.
- R8: burstDone while not owning the bus has no effect. An idle block stays idle, and a requesting block keeps requesting.
- R9: Each claim serves one burst. After release the block asks for the bus again only when a new demand arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dmaReq | input | 1 | One-cycle demand for the bus from the DMA engine |
| burstDone | input | 1 | DMA engine finished its burst; give the bus up |
| busReqN | output | 1 | Active-low bus request |
| busGrantN | input | 1 | Active-low bus grant arriving at this master |
| busAckIn | input | 1 | Sensed level of the shared grant-acknowledge line |
| busAckOutN | output | 1 | Value driven onto grant-acknowledge when enabled |
| busAckOe | output | 1 | Output enable for the grant-acknowledge driver |
| strobeN | input | 1 | Active-low data strobe of the current bus cycle |
| xferAckN | input | 1 | Active-low transfer acknowledge of the current bus cycle |
| busOwned | output | 1 | This master owns the bus |

## Verification
The bench models a previous owner that keeps grant-acknowledge low for a random number of cycles and keeps the strobe low for a further random stretch after releasing it. At every claim it checks that the inputs sampled at the synchronizer's depth were all idle. A design that trusts the raw grant, skips the acknowledge wait, or ignores the cycle in flight would claim the bus while the old owner still drives it. The bench also checks the order of the claim edge and the request release, because a design that drops its request early could lose the grant to another master. It pulses burstDone while idle and while requesting, because a design that reacts to it there would skip a burst or drop its request.

// File: rtl/busClaimPkg.sv
package busClaimPkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ASK     = 3'd1,
    ST_HOLDOFF = 3'd2,
    ST_DRAIN   = 3'd3,
    ST_CLAIM   = 3'd4,
    ST_OWN     = 3'd5,
    ST_LEAVE   = 3'd6
  } claimState_t;

  // strobes from control to the output drivers
  typedef struct packed {
    logic driveReq;
    logic driveAck;
    logic releaseAck;
  } driveStrobe_t;

  // synchronized view of the shared bus
  typedef struct packed {
    logic grantLow;
    logic ackFree;
    logic cycleIdle;
  } busView_t;

endpackage

// File: rtl/busClaimSync.sv
module busClaimSync #(
  parameter int STAGES   = 2,
  parameter bit RESETVAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RESETVAL}};
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/busClaimPath.sv
module busClaimPath
  import busClaimPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busGrantN,
  input  logic         busAckIn,
  input  logic         strobeN,
  input  logic         xferAckN,
  input  driveStrobe_t strobe,
  output busView_t     view,
  output logic         busReqN,
  output logic         busAckOutN,
  output logic         busAckOe,
  output logic         busOwned
);
  localparam int LINES = 4;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;

  assign rawLines = {busGrantN, busAckIn, strobeN, xferAckN};

  for (genvar g = 0; g < LINES; g++) begin : gSync
    busClaimSync #(.STAGES(SYNC_STAGES), .RESETVAL(1'b1)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(rawLines[g]),
      .syncOut(syncLines[g])
    );
  end

  assign view.grantLow  = !syncLines[3];
  assign view.ackFree   = syncLines[2];
  assign view.cycleIdle = syncLines[1] && syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReqN    <= 1'b1;
      busAckOutN <= 1'b1;
      busAckOe   <= 1'b0;
      busOwned   <= 1'b0;
    end else begin
      busReqN    <= !strobe.driveReq;
      busAckOutN <= !strobe.driveAck;
      busAckOe   <= strobe.driveAck || strobe.releaseAck;
      busOwned   <= strobe.driveAck;
    end
  end

  // R5: a claim edge follows a synchronized view of a granted, free, idle bus
  assert_claim_on_idle_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAckOutN) |-> $past(view.grantLow && view.ackFree && view.cycleIdle));

  // R6: the request is withdrawn only while the claim is already driven
  assert_req_drop_after_claim_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReqN) |-> $past(busAckOe && !busAckOutN));

  // R7: the driver is disabled only after one cycle of driving high
  assert_release_high_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAckOe) |-> $past(busAckOutN));

  // R7: releasing the acknowledge line keeps the driver enabled for that cycle
  assert_release_driven_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAckOutN) |-> busAckOe);
endmodule

// File: rtl/busClaimCtrl.sv
module busClaimCtrl
  import busClaimPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         dmaReq,
  input  logic         burstDone,
  input  busView_t     view,
  output driveStrobe_t strobe
);
  claimState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (dmaReq) stateD = ST_ASK;
      ST_ASK:     if (view.grantLow) stateD = view.ackFree ? ST_DRAIN : ST_HOLDOFF;
      ST_HOLDOFF: if (view.ackFree) stateD = ST_DRAIN;
      ST_DRAIN: begin
        if (!view.ackFree)       stateD = ST_HOLDOFF;
        else if (view.cycleIdle) stateD = ST_CLAIM;
      end
      ST_CLAIM:   stateD = burstDone ? ST_LEAVE : ST_OWN;
      ST_OWN:     if (burstDone) stateD = ST_LEAVE;
      ST_LEAVE:   stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.driveReq   = (stateD == ST_ASK) || (stateD == ST_HOLDOFF) ||
                        (stateD == ST_DRAIN) || (stateD == ST_CLAIM);
    strobe.driveAck   = (stateD == ST_CLAIM) || (stateD == ST_OWN);
    strobe.releaseAck = (stateD == ST_LEAVE);
  end

  // R2: a demand in idle starts the request
  assert_demand_starts_ask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && dmaReq) |=> (stateQ == ST_ASK));

  // R8: without a demand, idle is left alone whatever burstDone does
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !dmaReq) |=> (stateQ == ST_IDLE));

  // R9: release always returns to idle
  assert_leave_to_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LEAVE) |=> (stateQ == ST_IDLE));
endmodule

// File: rtl/busClaimer.sv
module busClaimer
  import busClaimPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dmaReq,
  input  logic burstDone,
  output logic busReqN,
  input  logic busGrantN,
  input  logic busAckIn,
  output logic busAckOutN,
  output logic busAckOe,
  input  logic strobeN,
  input  logic xferAckN,
  output logic busOwned
);
  driveStrobe_t strobe;
  busView_t     view;

  busClaimCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .dmaReq   (dmaReq),
    .burstDone(burstDone),
    .view     (view),
    .strobe   (strobe)
  );

  busClaimPath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .busGrantN (busGrantN),
    .busAckIn  (busAckIn),
    .strobeN   (strobeN),
    .xferAckN  (xferAckN),
    .strobe    (strobe),
    .view      (view),
    .busReqN   (busReqN),
    .busAckOutN(busAckOutN),
    .busAckOe  (busAckOe),
    .busOwned  (busOwned)
  );
endmodule

// File: tb/busClaimer_test.sv
module busClaimer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaReq = 1'b0, burstDone = 1'b0;
  logic bgN = 1'b1, prevAckN = 1'b1, dsN = 1'b1, dtackN = 1'b1;
  logic busReqN, busAckOutN, busAckOe, busOwned;
  logic ackWire;

  int total = 0;
  int bad = 0;

  // shared open-drain acknowledge line: previous owner and this master
  assign ackWire = prevAckN && (busAckOe ? busAckOutN : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  busClaimer uut (
    .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .burstDone(burstDone),
    .busReqN(busReqN), .busGrantN(bgN), .busAckIn(ackWire),
    .busAckOutN(busAckOutN), .busAckOe(busAckOe),
    .strobeN(dsN), .xferAckN(dtackN), .busOwned(busOwned)
  );

  // behavioural reference: 0 idle,1 asking,2 wait ack,3 wait cycle,4 claim,5 own,6 leave
  int mSt = 0;
  bit q1 [4], q2 [4];   // 0 grant,1 ack,2 ds,3 dtack

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0;
      for (int i = 0; i < 4; i++) begin q1[i] = 1; q2[i] = 1; end
    end else begin
      int nx;
      nx = mSt;
      case (mSt)
        0: if (dmaReq) nx = 1;
        1: if (!q2[0]) nx = q2[1] ? 3 : 2;
        2: if (q2[1]) nx = 3;
        3: if (!q2[1]) nx = 2; else if (q2[2] && q2[3]) nx = 4;
        4: nx = burstDone ? 6 : 5;
        5: if (burstDone) nx = 6;
        default: nx = 0;
      endcase
      q2 = q1;
      q1[0] = bgN; q1[1] = ackWire; q1[2] = dsN; q1[3] = dtackN;
      mSt = nx;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  bit h1 = 0, h2 = 0, h3 = 0;
  bit a1 = 0, a2 = 0, a3 = 0;
  logic prevOwned = 1'b0;
  bit claimSeen = 0;

  task automatic tick();
    h3 = h2; h2 = h1; h1 = (!bgN) && dsN && dtackN;
    a3 = a2; a2 = a1; a1 = ackWire;
    @(posedge clk);
    @(negedge clk);
    check("R2 busReqN vs model", busReqN, !(mSt >= 1 && mSt <= 4));
    check("R6 busOwned vs model", busOwned, (mSt == 4 || mSt == 5));
    check("R6 busAckOutN vs model", busAckOutN, !(mSt == 4 || mSt == 5));
    check("R7 busAckOe vs model", busAckOe, (mSt >= 4 && mSt <= 6));
    if (claimSeen) begin
      check("R6 request released after claim", busReqN, 1'b1);
      claimSeen = 0;
    end
    if (busOwned && !prevOwned) begin
      check("R4 acknowledge free before claim", a3, 1'b1);
      check("R5 grant and idle cycle before claim", h3, 1'b1);
      check("R6 request still low in claim cycle", busReqN, 1'b0);
      claimSeen = 1;
    end
    prevOwned = busOwned;
  endtask

  task automatic runBurst(input int grantDelay, input int ackHold,
                          input int dsHold, input int ownLen, input bit pokeDone);
    int k;
    dmaReq = 1; tick(); dmaReq = 0;
    check("R2 request driven after demand", busReqN, 1'b0);
    if (pokeDone) begin
      burstDone = 1; tick(); burstDone = 0;
      check("R8 burstDone while requesting keeps request", busReqN, 1'b0);
      check("R8 burstDone while requesting no ownership", busOwned, 1'b0);
    end
    for (int i = 0; i < grantDelay; i++) begin
      tick();
      check("R3 no ownership before grant", busOwned, 1'b0);
    end
    prevAckN = (ackHold > 0) ? 1'b0 : 1'b1;
    dsN = (dsHold > 0) ? 1'b0 : 1'b1;
    dtackN = dsN;
    bgN = 0;
    k = 0;
    while (!busOwned && k < 300) begin
      tick();
      k++;
      if (k >= ackHold) prevAckN = 1;
      if (k >= ackHold + dsHold) begin dsN = 1; dtackN = 1; end
    end
    check("R3 bus eventually claimed", busOwned, 1'b1);
    for (int i = 0; i < ownLen; i++) tick();
    burstDone = 1; tick(); burstDone = 0;
    bgN = 1;
    check("R7 release drives acknowledge high", busAckOutN, 1'b1);
    check("R7 release keeps driver enabled", busAckOe, 1'b1);
    check("R7 ownership dropped on release", busOwned, 1'b0);
    tick();
    check("R7 driver disabled after release", busAckOe, 1'b0);
    for (int i = 0; i < 4; i++) tick();
    check("R9 no new request without demand", busReqN, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busReqN", busReqN, 1'b1);
    check("R1 reset busAckOutN", busAckOutN, 1'b1);
    check("R1 reset busAckOe", busAckOe, 1'b0);
    check("R1 reset busOwned", busOwned, 1'b0);
    rstN = 1;
    tick(); tick();
    check("R1 idle after reset", busReqN, 1'b1);
    burstDone = 1; tick(); burstDone = 0;
    check("R8 burstDone in idle no request", busReqN, 1'b1);
    check("R8 burstDone in idle no driver", busAckOe, 1'b0);
    runBurst(0, 0, 0, 1, 0);    // free bus, immediate grant
    runBurst(3, 6, 0, 2, 1);    // previous owner holds acknowledge
    runBurst(1, 0, 5, 3, 0);    // cycle in flight only
    runBurst(2, 4, 4, 0, 0);    // both waits, shortest ownership
    for (int r = 0; r < 8; r++)
      runBurst($urandom_range(0, 5), $urandom_range(0, 12),
               $urandom_range(0, 8), $urandom_range(0, 4), r[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule